// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block drives the strobes and the 8-bit data bus of an asynchronous NAND flash device. It runs four kinds of bus cycle: command write, address write, data write and data read. A requester offers one cycle at a time: a one-tick `req` pulse while `ready` is high, together with the cycle kind, the byte to write and two stretch fields. One field widens the write strobe and the other widens the read strobe. The block then sequences chip enable, the two latch enables, the write or read strobe and the data bus. It pulses `done` once every hold time of the cycle has elapsed. A read returns its captured byte on `rdata`, valid with `done`.

The block is clocked by a tick that runs at twice the system clock, so one system clock equals two ticks. Every edge the device sees can therefore be placed on a half-clock boundary. All widths below are given in ticks. Chip enable leads the strobe by one system clock. Chip enable, the latch enables and the write data stay held for three system clocks after the strobe rises. A read that follows any write-type cycle gets one extra setup tick, so that at least five system clocks separate the write strobe rise from the read strobe fall.

Top module: `nand_seq`

## Requirements
- R1: After reset and whenever idle: `ce_n`, `we_n` and `re_n` are 1, `cle`, `ale` and `done` are 0, `ready` is 1 and the data bus is released.
- R2: A request is taken only on a tick edge where `req` is 1 and `ready` is 1. A `req` pulse while a cycle runs is ignored: no further cycle follows and its kind and stretch values have no effect. Kind encoding: 0 = command write, 1 = address write, 2 = data write, 3 = data read.
- R3: `ce_n` goes low in the first tick after the request is taken. The strobe of the cycle falls 2 ticks after that. For a read whose previous cycle was of kind 0, 1 or 2, it falls 3 ticks after that instead.
- R4: `we_n` stays low for 2*(wr_dly+1) ticks on kinds 0 to 2, and `re_n` stays low for 2*(rd_dly+1) ticks on kind 3. Both fields are sampled when the request is taken.
- R5: `cle` is 1 only for kind 0 and `ale` is 1 only for kind 1. Either one rises with `ce_n` falling and stays constant until `ce_n` rises, so it is valid at the strobe fall.
- R6: On kinds 0 to 2 the sequencer drives the request byte on `dq` from the first tick of the cycle until `ce_n` rises, which is 6 ticks after `we_n` rises. It never drives `dq` while `re_n` is low.
- R7: On a read, the `dq` value present in the last tick before `re_n` rises is captured and shown on `rdata` with `done`.
- R8: `ce_n` rises 6 ticks after the strobe rises. In that same tick `done` is 1 for exactly one tick and `ready` returns to 1.
- R9: When a read request is taken in the tick `done` of a preceding write-type cycle is seen, exactly 10 ticks pass from the `we_n` rise to the `re_n` fall.
- R10: `we_n` and `re_n` are never low at the same time, and the strobe that does not belong to the cycle kind stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request pulse, taken while `ready` is 1 |
| kind | input | 2 | Cycle kind: 0 command, 1 address, 2 data write, 3 data read |
| wdata | input | 8 | Byte for a write-type cycle |
| wr_dly | input | 4 | Write strobe stretch in system clocks |
| rd_dly | input | 4 | Read strobe stretch in system clocks |
| ready | output | 1 | Idle, able to take a request |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq | inout | 8 | Bidirectional flash data bus |
| rdata | output | 8 | Byte captured by the last read |
| done | output | 1 | One-tick completion pulse |

## Verification
Each result has a due tick counted from the edge that takes the request. Chip enable is low in tick 0. The strobe falls in tick 2, or in tick 3 for a read after a write. It rises 2*(dly+1) ticks later. Chip enable rises and `done` pulses 6 ticks after that, and `rdata` is read in the `done` tick. The bench samples every output on the falling clock edge, one tick per loop pass, and records the tick in which each edge first appears. It compares those ticks with the sums above. Back-to-back cycles are issued in the very tick `done` shows, so the 10-tick write-to-read gap is measured at its minimum.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int DW = 8,
  parameter int DLYW = 4,
  parameter int SETUP_T = 2,
  parameter int TURN_T = 1,
  parameter int HOLD_T = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [1:0]      kind,
  input  logic [DW-1:0]   wdata,
  input  logic [DLYW-1:0] wr_dly,
  input  logic [DLYW-1:0] rd_dly,
  output logic            ready,
  output logic            ce_n,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  inout  wire  [DW-1:0]   dq,
  output logic [DW-1:0]   rdata,
  output logic            done
);
  localparam int CW = DLYW + 2;
  localparam logic [1:0] K_CMD = 2'd0, K_ADR = 2'd1, K_RD = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [1:0]      kd;
  logic [DLYW-1:0] dly;
  logic [DW-1:0]   wq;
  logic [DW-1:0]   rq;
  logic            last_wr;
  logic            done_q;
  logic            is_rd;
  logic            dq_oe;

  assign is_rd = (kd == K_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      kd      <= '0;
      dly     <= '0;
      wq      <= '0;
      rq      <= '0;
      last_wr <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st  <= S_SETUP;
          kd  <= kind;
          wq  <= wdata;
          dly <= (kind == K_RD) ? rd_dly : wr_dly;
          cnt <= (kind == K_RD && last_wr) ? CW'(SETUP_T + TURN_T - 1) : CW'(SETUP_T - 1);
        end
        S_SETUP: if (cnt == '0) begin
          st  <= S_STRB;
          cnt <= CW'({dly, 1'b1});
        end else cnt <= cnt - 1'b1;
        S_STRB: if (cnt == '0) begin
          st      <= S_HOLD;
          cnt     <= CW'(HOLD_T - 1);
          last_wr <= !is_rd;
          if (is_rd) rq <= dq;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign ready = (st == S_IDLE);
  assign ce_n  = ready;
  assign cle   = !ready && kd == K_CMD;
  assign ale   = !ready && kd == K_ADR;
  assign we_n  = !(st == S_STRB && !is_rd);
  assign re_n  = !(st == S_STRB && is_rd);
  assign dq_oe = !ready && !is_rd;
  assign dq    = dq_oe ? wq : 'z;
  assign rdata = rq;
  assign done  = done_q;
endmodule

module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic oe,
  input logic done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && we_n && re_n && !cle && !ale && !oe));

  p_ce_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> $past(!ce_n));

  p_one_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cle, ale}));

  p_latch_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> ($stable(cle) && $stable(ale)));

  p_bus_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !oe);

  p_ce_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) || $rose(re_n)) |-> !ce_n);

  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && $past(!ce_n)));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> re_n);
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .ce_n(ce_n), .cle(cle), .ale(ale),
  .we_n(we_n), .re_n(re_n), .oe(dq_oe), .done(done)
);

// File: tb/sim_nand_seq.sv
`timescale 1ns/1ps
module sim_nand_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [1:0] kind = '0;
  logic [7:0] wdata = '0;
  logic [3:0] wr_dly = '0;
  logic [3:0] rd_dly = '0;
  logic ready, ce_n, cle, ale, we_n, re_n, done;
  logic [7:0] rdata;
  wire  [7:0] dq;
  logic [7:0] fl_byte = '0;
  int total = 0;
  int bad = 0;
  int tk = 0;
  int last_we_tk = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) tk <= tk + 1;

  assign dq = re_n ? 8'hzz : fl_byte;

  nand_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .kind(kind), .wdata(wdata),
    .wr_dly(wr_dly), .rd_dly(rd_dly), .ready(ready), .ce_n(ce_n), .cle(cle),
    .ale(ale), .we_n(we_n), .re_n(re_n), .dq(dq), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    chk(ce_n && we_n && re_n, "R1 strobes idle", {ce_n, we_n, re_n}, 3'b111);
    chk(!cle && !ale && !done, "R1 latches/done low", {cle, ale, done}, 3'b000);
    chk(ready, "R1 ready", ready, 1);
  endtask

  // Must be called at a falling clock edge; returns at the falling edge that shows done.
  task automatic run_cyc(input [1:0] k, input [7:0] wv, input [3:0] wdl, input [3:0] rdl,
                         input int s_exp, input bit poke, output int gap);
    int L, fall_n, rise_n, ceup_n, done_n, other, fall_tk;
    logic sb, ce0, cl_f, al_f;
    logic [7:0] dq_f, dq_h, rd_got;
    L = 2 * (((k == 2'd3) ? int'(rdl) : int'(wdl)) + 1);
    fall_n = -1; rise_n = -1; ceup_n = -1; done_n = -1; other = 0; fall_tk = 0; gap = 0;
    ce0 = 1'b1; cl_f = 1'b0; al_f = 1'b0; dq_f = '0; dq_h = '0; rd_got = '0;
    kind = k; wdata = wv; wr_dly = wdl; rd_dly = rdl; fl_byte = wv ^ 8'h5a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int n = 0; n < 80; n++) begin
      sb = (k == 2'd3) ? re_n : we_n;
      if (n == 0) ce0 = ce_n;
      if (fall_n < 0 && !sb) begin fall_n = n; fall_tk = tk; cl_f = cle; al_f = ale; dq_f = dq; end
      if (fall_n >= 0 && rise_n < 0 && sb) begin
        rise_n = n;
        if (k != 2'd3) last_we_tk = tk;
      end
      if (rise_n >= 0 && n == rise_n + 5) dq_h = dq;
      if (rise_n >= 0 && ceup_n < 0 && ce_n) ceup_n = n;
      if (((k == 2'd3) ? we_n : re_n) == 1'b0) other++;
      if (poke && n == 1) begin req = 1'b1; kind = 2'd3; wr_dly = 4'hf; rd_dly = 4'hf; end
      if (poke && n == 2) req = 1'b0;
      if (done) begin done_n = n; rd_got = rdata; break; end
      @(negedge clk);
    end
    chk(ce0 == 1'b0, "R3 ce low first tick", ce0, 0);
    chk(fall_n == s_exp, "R3 strobe fall tick", fall_n, s_exp);
    chk(rise_n - fall_n == L, "R4 strobe low width", rise_n - fall_n, L);
    chk(ceup_n == rise_n + 6, "R8 ce hold", ceup_n - rise_n, 6);
    chk(done_n == rise_n + 6, "R8 done tick", done_n - rise_n, 6);
    chk({cl_f, al_f} == ((k == 2'd0) ? 2'b10 : (k == 2'd1) ? 2'b01 : 2'b00),
        "R5 latch enables", {cl_f, al_f}, k);
    chk(other == 0, "R10 other strobe quiet", other, 0);
    if (k != 2'd3) begin
      chk(dq_f == wv, "R6 write data at fall", dq_f, wv);
      chk(dq_h == wv, "R6 write data hold", dq_h, wv);
    end else begin
      chk(dq_f == (wv ^ 8'h5a), "R6 bus free on read", dq_f, wv ^ 8'h5a);
      chk(rd_got == (wv ^ 8'h5a), "R7 read capture", rd_got, wv ^ 8'h5a);
      gap = fall_tk - last_we_tk;
    end
  endtask

  task automatic t_cmd_addr();
    int g;
    run_cyc(2'd0, 8'h70, 4'd0, 4'd0, 2, 1'b0, g);
    run_cyc(2'd1, 8'h3c, 4'd3, 4'd9, 2, 1'b0, g);
  endtask

  task automatic t_turnaround();
    int g;
    run_cyc(2'd3, 8'ha1, 4'd7, 4'd2, 3, 1'b0, g);
    chk(g == 10, "R9 write-to-read gap", g, 10);
    run_cyc(2'd3, 8'h0f, 4'd0, 4'd15, 2, 1'b0, g);
  endtask

  task automatic t_busy_ignore();
    int g;
    int starts;
    run_cyc(2'd2, 8'hc3, 4'd15, 4'd0, 2, 1'b1, g);
    starts = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!ce_n || !re_n || !ready) starts++;
    end
    chk(starts == 0, "R2 busy request ignored", starts, 0);
    t_reset();
  endtask

  task automatic t_late_read();
    int g;
    repeat (5) @(negedge clk);
    run_cyc(2'd3, 8'h96, 4'd0, 4'd0, 3, 1'b0, g);
    chk(g >= 10, "R9 gap after idle", g, 10);
    run_cyc(2'd2, 8'h55, 4'd5, 4'd0, 2, 1'b0, g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_addr();
    t_turnaround();
    t_busy_ignore();
    t_late_read();
    repeat (3) @(negedge clk);
    t_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule